// File: doc/BRIEF.md
# Accumulator Read Scaler and Limiter

This block sits between a wide fractional accumulator and a 24-bit data bus. When a read is requested, it takes the 56-bit accumulator value and scales it by one binary place. The value is made of an 8-bit guard extension above a 24-bit high word and a 24-bit low word. A two-bit mode picks the scaling: left, right, or none. The block then narrows the scaled value to a 24-bit two's-complement fraction.

If the scaled value cannot be represented in 24 bits, the block clips it. A positive value becomes the largest positive fraction and a negative value becomes the most negative fraction. The clip also sets an error flag. The flag stays set until software-side logic clears it explicitly. This lets block-scaled algorithms adjust the scale of each pass without extra instructions. They can still find out afterwards whether any sample was clipped.

The result is registered, so the word appears one clock after the read strobe. A valid pulse marks that word.

Top module: `acc_read_scaler`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rd_data` is 0, `rd_valid` is 0 and `limit_flag` is 0.
- R2: `scale_mode` encoding: 2'b00 means no shift, 2'b01 means an arithmetic shift right by one, 2'b10 means a shift left by one, and 2'b11 behaves exactly like 2'b00.
- R3: With no shift, when bits 55..47 of `acc_in` are all equal, `rd_data` is `acc_in[47:24]`, truncated without rounding.
- R4: With the right shift, the value fits when bits 55..48 are all equal. `rd_data` is then `acc_in[48:25]`, which equals the high word of floor(acc/2).
- R5: With the left shift, the value fits when bits 55..46 are all equal, so the bit shifted out must match the sign. `rd_data` is then `acc_in[46:23]`.
- R6: When the scaled value does not fit, `rd_data` is 24'h7FFFFF if `acc_in[55]` is 0, and 24'h800000 if it is 1.
- R7: `rd_valid` is high for exactly the cycle after each cycle with `rd_en` high. `rd_data` changes only in the cycle after `rd_en`, and otherwise holds its value.
- R8: `limit_flag` goes high in the cycle after a read that clipped. It then stays high until cleared. A clip and a `flag_clr` in the same cycle leave the flag set.
- R9: `flag_clr` in a cycle without a clipping read makes `limit_flag` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; captures a scaled word |
| acc_in | input | 56 | Accumulator value {ext[7:0], high[23:0], low[23:0]} |
| scale_mode | input | 2 | Scaling mode (see R2) |
| flag_clr | input | 1 | Clears the sticky limit flag |
| rd_data | output | 24 | Scaled and limited word |
| rd_valid | output | 1 | Marks the cycle in which `rd_data` holds a new read |
| limit_flag | output | 1 | Sticky clip indication |

## Verification
The bench sweeps every scaling mode across values at each power-of-two magnitude and its neighbours, with both signs, and across pseudo-random values spread over the whole dynamic range. Each result is compared against integer arithmetic on the signed value.

The sweep targets several edges:
- Values exactly at the fit boundaries. A limiter that compared one bit too few or too many would clip legal values, or wrap large ones into a wrong sign.
- Left shifts whose shifted-out bit differs from the new top bit. Without the spill check, these would come out as plausible-looking but wrong words.
- Negative odd values under the right shift. Rounding toward zero there would miss floor by one least significant bit.
- The sticky flag, held through clean reads and tested with a clear that coincides with a clip. A design that let the clear win would lose the error.

// File: rtl/acc_scale_pkg.sv
package acc_scale_pkg;

    localparam int EXT_W  = 8;
    localparam int WORD_W = 24;
    localparam int ACC_W  = EXT_W + 2 * WORD_W;
    localparam int CHK_W  = EXT_W + 2;   // spill + extension + high-word MSB

    typedef enum logic [1:0] {
        SCALE_NONE = 2'b00,
        SCALE_DOWN = 2'b01,
        SCALE_UP   = 2'b10,
        SCALE_RSVD = 2'b11
    } scale_mode_e;

    typedef struct packed {
        logic [ACC_W-1:0] value;   // scaled accumulator
        logic             spill;   // bit lost off the top (sign copy if none)
    } scaled_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              clipped;
    } limit_t;

    function automatic logic bits_agree(input logic [CHK_W-1:0] b);
        return (&b) | ~(|b);
    endfunction

    function automatic logic [WORD_W-1:0] clip_word(input logic negative);
        return negative ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/acc_scale_shift.sv
module acc_scale_shift
    import acc_scale_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  scale_mode_e      mode_i,
    output scaled_t          scaled_o
);
    localparam int TOP = ACC_W - 1;

    always_comb begin
        scaled_o.spill = acc_i[TOP];
        unique case (mode_i)
            SCALE_DOWN: scaled_o.value = {acc_i[TOP], acc_i[TOP:1]};
            SCALE_UP:   scaled_o.value = {acc_i[TOP-1:0], 1'b0};
            default:    scaled_o.value = acc_i;   // none and reserved
        endcase
    end
endmodule

// File: rtl/acc_scale_limit.sv
module acc_scale_limit
    import acc_scale_pkg::*;
(
    input  scaled_t scaled_i,
    input  logic    sign_i,
    output limit_t  result_o
);
    localparam int HI_LSB = WORD_W;
    localparam int HI_MSB = 2 * WORD_W - 1;

    logic fits;

    always_comb begin
        fits = bits_agree({scaled_i.spill, scaled_i.value[ACC_W-1:HI_MSB]});
        result_o.clipped = ~fits;
        result_o.word    = fits ? scaled_i.value[HI_MSB:HI_LSB] : clip_word(sign_i);
    end
endmodule

// File: rtl/acc_read_scaler.sv
module acc_read_scaler
    import acc_scale_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [1:0]        scale_mode,
    input  logic              flag_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              limit_flag
);
    scaled_t scaled;
    limit_t  lim;

    acc_scale_shift u_shift (
        .acc_i    (acc_in),
        .mode_i   (scale_mode_e'(scale_mode)),
        .scaled_o (scaled)
    );

    acc_scale_limit u_limit (
        .scaled_i (scaled),
        .sign_i   (acc_in[ACC_W-1]),
        .result_o (lim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            limit_flag <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= lim.word;
            if (rd_en && lim.clipped) limit_flag <= 1'b1;   // set wins over clear
            else if (flag_clr)        limit_flag <= 1'b0;
        end
    end

    AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);                                               // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));                                      // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (limit_flag && !flag_clr) |=> limit_flag);                         // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(rd_en && lim.clipped)) |=> !limit_flag);            // R9
    AST_NOSHIFT_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && scale_mode == 2'b00 && (&acc_in[55:47] || !(|acc_in[55:47])))
        |=> rd_data == $past(acc_in[47:24]));                              // R3
    AST_DOWN_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && scale_mode == 2'b01 && (&acc_in[55:48] || !(|acc_in[55:48])))
        |=> rd_data == $past(acc_in[48:25]));                              // R4
    AST_UP_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && scale_mode == 2'b10 && (&acc_in[55:46] || !(|acc_in[55:46])))
        |=> rd_data == $past(acc_in[46:23]));                              // R5
endmodule

// File: tb/acc_read_scaler_tb_top.sv
module acc_read_scaler_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en;
    logic [55:0] acc_in;
    logic [1:0]  scale_mode;
    logic        flag_clr;
    logic [23:0] rd_data;
    logic        rd_valid;
    logic        limit_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;   // 50 MHz

    acc_read_scaler dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .acc_in(acc_in),
        .scale_mode(scale_mode), .flag_clr(flag_clr),
        .rd_data(rd_data), .rd_valid(rd_valid), .limit_flag(limit_flag)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected word and clip from integer arithmetic on the signed value.
    task automatic model(input longint v, input logic [1:0] m,
                         output logic [23:0] w, output logic clip);
        longint s;
        longint hi = (64'sd1 <<< 47) - 1;
        longint lo = -(64'sd1 <<< 47);
        if (m == 2'b01)      s = v >>> 1;
        else if (m == 2'b10) s = v * 2;
        else                 s = v;
        clip = (s > hi) || (s < lo);
        if (clip) w = (v < 0) ? 24'h800000 : 24'h7FFFFF;
        else      w = 24'(s >>> 24);
    endtask

    // Read with the clear asserted, so the flag reflects this read alone.
    task automatic one_read(input longint v, input logic [1:0] m);
        logic [23:0] ew;
        logic ec;
        string tag;
        model(v, m, ew, ec);
        tag = ec ? "R6" : (m == 2'b01 ? "R4" : (m == 2'b10 ? "R5" : "R3"));
        if (m == 2'b11) tag = "R2";
        @(negedge clk);
        rd_en = 1; acc_in = v[55:0]; scale_mode = m; flag_clr = 1;
        @(negedge clk);
        rd_en = 0; flag_clr = 0;
        check(tag, rd_data, ew);
        check("R8", limit_flag, ec);
        check("R7", rd_valid, 1);
    endtask

    task automatic sweep_value(input longint v);
        for (int m = 0; m < 4; m++) one_read(v, 2'(m));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; rd_en = 0; acc_in = '0; scale_mode = 0; flag_clr = 0;
        @(negedge clk);
        check("R1", rd_data, 0); check("R1", rd_valid, 0); check("R1", limit_flag, 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check("R1", rd_data, 0); check("R1", rd_valid, 0); check("R1", limit_flag, 0);

        // Magnitude boundaries of both signs, every mode.
        for (int k = 0; k < 55; k++) begin
            for (int d = -1; d <= 1; d++) begin
                sweep_value((64'sd1 <<< k) + d);
                sweep_value(-(64'sd1 <<< k) + d);
            end
        end
        sweep_value(-(64'sd1 <<< 55));
        sweep_value((64'sd1 <<< 55) - 1);

        // Pseudo-random values spread over the range.
        for (int i = 0; i < 300; i++) begin
            longint v;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            v = $signed(lfsr) >>> (8 + (lfsr[5:0] % 48));
            sweep_value(v);
        end

        // R7: no read -> valid low, data held.
        begin
            logic [23:0] held;
            held = rd_data;
            @(negedge clk);
            acc_in = 56'h12_345678_9ABCDE; scale_mode = 2'b00;
            @(negedge clk);
            check("R7", rd_valid, 0);
            check("R7", rd_data, held);
        end

        // R8: clip sets flag; clean reads keep it set.
        @(negedge clk); rd_en = 1; acc_in = 56'h01_000000_000000; scale_mode = 2'b00;
        @(negedge clk); rd_en = 0;
        check("R8", limit_flag, 1); check("R6", rd_data, 24'h7FFFFF);
        @(negedge clk); rd_en = 1; acc_in = 56'h00_100000_000000;
        @(negedge clk); rd_en = 0;
        check("R8", limit_flag, 1); check("R3", rd_data, 24'h100000);
        @(negedge clk);
        check("R8", limit_flag, 1);
        // R8: clear with a simultaneous clip keeps the flag.
        @(negedge clk); rd_en = 1; flag_clr = 1; acc_in = 56'hFE_000000_000000;
        @(negedge clk); rd_en = 0; flag_clr = 0;
        check("R8", limit_flag, 1); check("R6", rd_data, 24'h800000);
        // R9: plain clear.
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        check("R9", limit_flag, 0);
        // R9: clear during a clean read.
        @(negedge clk); rd_en = 1; acc_in = 56'h80_000000_000000; scale_mode = 2'b01;
        @(negedge clk); rd_en = 0;
        check("R8", limit_flag, 1);
        @(negedge clk); rd_en = 1; flag_clr = 1; acc_in = 56'hFF_C00000_000001; scale_mode = 2'b10;
        @(negedge clk); rd_en = 0; flag_clr = 0;
        check("R9", limit_flag, 0); check("R5", rd_data, 24'h800000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule